// File: doc/BRIEF.md
# Constant Off-Time Bridge Current Limiter

This block keeps the load current of a motor bridge in check by chopping it. Two threshold comparators report the current against a nominal regulation level and a lower, thermally derated level. A foldback flag selects which of the two is in force. When the selected comparator trips while the bridge is conducting, the block forces every bridge switch off for a fixed number of timebase ticks. After that the bridge goes back to whatever the command inputs ask for.

Every output transition opens a blanking window. The end of an off-time counts as a transition, because the outputs switch back on. During the window the regulation comparator is ignored, so only the short-circuit comparators can act. A short-circuit comparator firing while the bridge conducts raises a one-cycle request toward the external fault latch. That request takes priority over regulation. A guard timer also keeps successive regulation trips far enough apart that the chopping frequency stays bounded.

All durations count pulses of a timebase enable (nominally 1 MHz). The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clocks after `rst_n` rises.

Top module: `chop_limiter`

## Requirements
- R1: While in reset and after reset, force_off_o, blank_o and short_req_o are 0, and all timers are idle.
- R2: While neither off-time nor blanking nor the period guard is active and no short input is high, a high selected limit comparator sets force_off_o from the next clock.
- R3: An off-time keeps force_off_o high for exactly OFF_TICKS sampled tick_i pulses (default 20), then releases it.
- R4: A limit trip seen while force_off_o is high is ignored: the off-time is not restarted or extended.
- R5: A pulse on edge_i sets blank_o from the next clock and (re)loads the window to BLANK_TICKS ticks (default 16). A new edge_i pulse inside a running window restarts the full window.
- R6: While blank_o is high, the limit comparators cannot start an off-time.
- R7: In the clock where an off-time ends, blanking restarts, so blank_o is high when force_off_o falls.
- R8: With hot_i high, only lim_lo_i acts as the limit comparator. With hot_i low, only lim_hi_i acts. The other comparator has no effect on force_off_o.
- R9: short_hs_i or short_ls_i high while force_off_o is low gives short_req_o high in the next clock, also inside a blanking window. The request lasts one clock per sampled cycle of the short input.
- R10: When a short input and the selected limit comparator are high in the same clock, the short wins: short_req_o rises and no off-time starts.
- R11: Short inputs are ignored while force_off_o is high.
- R12: A new off-time cannot start until PERIOD_TICKS ticks (default 50) have passed since the previous one started, whatever the comparators do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one clock per tick |
| edge_i | input | 1 | Strobe: a bridge output transition occurred |
| lim_hi_i | input | 1 | Current above nominal regulation level |
| lim_lo_i | input | 1 | Current above derated regulation level |
| hot_i | input | 1 | Thermal foldback active, selects lim_lo_i |
| short_hs_i | input | 1 | High-side short comparator (short to ground) |
| short_ls_i | input | 1 | Low-side short comparator (short to supply) |
| force_off_o | output | 1 | All bridge switches forced off |
| blank_o | output | 1 | Blanking window running |
| short_req_o | output | 1 | Short-circuit request to the fault latch |

## Verification
The hardest state to reach is the period guard holding off a trip. A trip has to start and its full off-time has to run. The blanking window that follows must then expire while the limit comparator is still held high. Only after that does a clock arrive in which every other condition allows a trip and the guard alone blocks it. The stimulus keeps lim_hi_i asserted through an entire off-time and the blanking window behind it. It then checks that force_off_o stays low until the guard expires, and that the output trips on its own once it does. A behavioural model with integer countdowns is compared with all three outputs on every clock, so even the exact tick on which each window ends is checked.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    TRIP_NONE  = 2'd0,
    TRIP_LIMIT = 2'd1,
    TRIP_SHORT = 2'd2
  } trip_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_bits(input int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = !load_i && tick_i && (cnt_q == W'(1));

endmodule

// File: rtl/chop_arbiter.sv
module chop_arbiter
  import chop_pkg::*;
(
  input  logic  lim_hi_i,
  input  logic  lim_lo_i,
  input  logic  hot_i,
  input  logic  short_hs_i,
  input  logic  short_ls_i,
  input  logic  forced_i,
  input  logic  blanking_i,
  input  logic  guard_i,
  output trip_e trip_o
);

  logic lim_sel;
  logic short_any;

  always_comb begin
    lim_sel   = hot_i ? lim_lo_i : lim_hi_i;
    short_any = short_hs_i | short_ls_i;
    trip_o    = TRIP_NONE;
    if (!forced_i) begin
      if (short_any) begin
        trip_o = TRIP_SHORT;
      end else if (lim_sel && !blanking_i && !guard_i) begin
        trip_o = TRIP_LIMIT;
      end
    end
  end

endmodule

// File: rtl/chop_limiter.sv
module chop_limiter
  import chop_pkg::*;
#(
  parameter int OFF_TICKS    = 20,
  parameter int BLANK_TICKS  = 16,
  parameter int PERIOD_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic edge_i,
  input  logic lim_hi_i,
  input  logic lim_lo_i,
  input  logic hot_i,
  input  logic short_hs_i,
  input  logic short_ls_i,
  output logic force_off_o,
  output logic blank_o,
  output logic short_req_o
);

  localparam int CW = cnt_bits(max3(OFF_TICKS, BLANK_TICKS, PERIOD_TICKS));

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  trip_e trip;
  logic  off_busy, off_done;
  logic  blank_busy, blank_done_unused;
  logic  guard_busy, guard_done_unused;
  logic  start_off;
  logic  short_hit;
  logic  blank_load;
  logic  short_req_d, short_req_q;

  chop_arbiter u_arb (
    .lim_hi_i   (lim_hi_i),
    .lim_lo_i   (lim_lo_i),
    .hot_i      (hot_i),
    .short_hs_i (short_hs_i),
    .short_ls_i (short_ls_i),
    .forced_i   (off_busy),
    .blanking_i (blank_busy),
    .guard_i    (guard_busy),
    .trip_o     (trip)
  );

  always_comb begin
    start_off   = (trip == TRIP_LIMIT);
    short_hit   = (trip == TRIP_SHORT);
    blank_load  = edge_i | off_done;
    short_req_d = short_hit;
  end

  chop_timer #(.W(CW)) u_off (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (start_off),
    .load_val_i (CW'(OFF_TICKS)),
    .busy_o     (off_busy),
    .done_o     (off_done)
  );

  chop_timer #(.W(CW)) u_blank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (blank_load),
    .load_val_i (CW'(BLANK_TICKS)),
    .busy_o     (blank_busy),
    .done_o     (blank_done_unused)
  );

  chop_timer #(.W(CW)) u_guard (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (start_off),
    .load_val_i (CW'(PERIOD_TICKS)),
    .busy_o     (guard_busy),
    .done_o     (guard_done_unused)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      short_req_q <= 1'b0;
    end else begin
      short_req_q <= short_req_d;
    end
  end

  assign force_off_o = off_busy;
  assign blank_o     = blank_busy;
  assign short_req_o = short_req_q;

endmodule

// File: rtl/chop_limiter_chk.sv
module chop_limiter_chk #(
  parameter int OFF_TICKS = 20
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic hot_i,
  input logic lim_hi_i,
  input logic lim_lo_i,
  input logic short_hs_i,
  input logic short_ls_i,
  input logic force_off_o,
  input logic blank_o,
  input logic short_req_o
);

  logic [31:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (force_off_o) begin
      seen_q <= seen_q + {31'd0, tick_i};
    end else begin
      seen_q <= '0;
    end
  end

  // R2
  limit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_off_o) |-> ($past(hot_i ? lim_lo_i : lim_hi_i) && !$past(blank_o)
                            && !$past(short_hs_i || short_ls_i)));

  // R3
  off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_off_o) |-> (seen_q == 32'(OFF_TICKS)));

  // R7
  reblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_off_o) |-> blank_o);

  // R9
  short_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_off_o && (short_hs_i || short_ls_i)) |=> short_req_o);

  // R10
  short_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_req_o |-> !$rose(force_off_o));

  // R11
  short_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_req_o |-> !$past(force_off_o));

endmodule

bind chop_limiter chop_limiter_chk #(.OFF_TICKS(OFF_TICKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .hot_i       (hot_i),
  .lim_hi_i    (lim_hi_i),
  .lim_lo_i    (lim_lo_i),
  .short_hs_i  (short_hs_i),
  .short_ls_i  (short_ls_i),
  .force_off_o (force_off_o),
  .blank_o     (blank_o),
  .short_req_o (short_req_o)
);

// File: tb/chop_limiter_test.sv
module chop_limiter_test;

  localparam int OFF_T   = 20;
  localparam int BLANK_T = 16;
  localparam int GUARD_T = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, edge_i = 1'b0, lim_hi_i = 1'b0, lim_lo_i = 1'b0;
  logic hot_i = 1'b0, short_hs_i = 1'b0, short_ls_i = 1'b0;
  logic force_off_o, blank_o, short_req_o;

  int checks = 0;
  int errors = 0;
  int divcnt = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chop_limiter #(.OFF_TICKS(OFF_T), .BLANK_TICKS(BLANK_T), .PERIOD_TICKS(GUARD_T)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .edge_i(edge_i),
    .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .hot_i(hot_i),
    .short_hs_i(short_hs_i), .short_ls_i(short_ls_i),
    .force_off_o(force_off_o), .blank_o(blank_o), .short_req_o(short_req_o)
  );

  // behavioural reference: remaining ticks of each window
  int  m_off = 0, m_blank = 0, m_guard = 0;
  bit  m_short = 0;

  always @(posedge clk) begin
    bit lim, forced, hit, start, fin;
    if (!rst_n) begin
      m_off = 0; m_blank = 0; m_guard = 0; m_short = 0;
    end else begin
      lim    = hot_i ? lim_lo_i : lim_hi_i;
      forced = (m_off > 0);
      hit    = (short_hs_i || short_ls_i) && !forced;
      start  = lim && !forced && (m_blank == 0) && (m_guard == 0) && !hit;
      fin    = (m_off == 1) && tick_i;
      if (start) m_off = OFF_T;
      else if (m_off > 0 && tick_i) m_off = m_off - 1;
      if (edge_i || fin) m_blank = BLANK_T;
      else if (m_blank > 0 && tick_i) m_blank = m_blank - 1;
      if (start) m_guard = GUARD_T;
      else if (m_guard > 0 && tick_i) m_guard = m_guard - 1;
      m_short = hit;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(force_off_o == (m_off > 0), "R2 R3 R4 R6 R8 R12 force_off_o", force_off_o, m_off > 0);
      check(blank_o == (m_blank > 0), "R5 R7 blank_o", blank_o, m_blank > 0);
      check(short_req_o == m_short, "R9 R10 R11 short_req_o", short_req_o, m_short);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    divcnt++;
    tick_i = (divcnt % 3 == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int n;
    steps(3);
    check(force_off_o == 0 && blank_o == 0 && short_req_o == 0, "R1", {force_off_o, blank_o, short_req_o}, 0);
    rst_n = 1'b1;
    steps(6);
    check(force_off_o == 0 && blank_o == 0 && short_req_o == 0, "R1", {force_off_o, blank_o, short_req_o}, 0);

    // blanking masks the limit, then trip
    edge_i = 1; step(); edge_i = 0; lim_hi_i = 1;
    check(blank_o == 1, "R5", blank_o, 1);
    while (blank_o) begin
      step();
      if (blank_o) check(force_off_o == 0, "R6", force_off_o, 0);
    end
    step();
    check(force_off_o == 1, "R2", force_off_o, 1);

    // shorts ignored during off-time, limit held high (no retrigger)
    n = 0;
    short_hs_i = 1;
    for (int i = 0; i < 3; i++) begin
      if (tick_i) n++;
      step();
      check(short_req_o == 0, "R11", short_req_o, 0);
    end
    short_hs_i = 0;
    while (force_off_o) begin
      if (tick_i) n++;
      step();
    end
    check(n == OFF_T, "R3 R4", n, OFF_T);
    check(blank_o == 1, "R7", blank_o, 1);

    // guard holds off after blanking ends
    while (blank_o) step();
    step();
    check(force_off_o == 0, "R12", force_off_o, 0);
    n = 0;
    while (!force_off_o && n < 2000) begin
      step();
      n++;
    end
    check(force_off_o == 1, "R12", force_off_o, 1);
    lim_hi_i = 0;
    steps(400);

    // foldback selection
    hot_i = 1; lim_hi_i = 1;
    steps(10);
    check(force_off_o == 0, "R8", force_off_o, 0);
    lim_lo_i = 1; step();
    check(force_off_o == 1, "R8", force_off_o, 1);
    lim_lo_i = 0; lim_hi_i = 0; hot_i = 0;
    steps(400);

    // short during blanking
    edge_i = 1; step(); edge_i = 0; short_ls_i = 1; step();
    check(short_req_o == 1 && blank_o == 1, "R9", {short_req_o, blank_o}, 3);
    short_ls_i = 0; step();
    check(short_req_o == 0, "R9", short_req_o, 0);
    steps(400);

    // short beats limit
    lim_hi_i = 1; short_hs_i = 1; step();
    check(short_req_o == 1, "R10", short_req_o, 1);
    check(force_off_o == 0, "R10", force_off_o, 0);
    lim_hi_i = 0; short_hs_i = 0; step();
    check(force_off_o == 0, "R10", force_off_o, 0);
    steps(100);

    // blanking restart by a second edge
    edge_i = 1; step(); edge_i = 0;
    n = 0;
    while (n < 4) begin
      if (tick_i) n++;
      step();
    end
    edge_i = 1; step(); edge_i = 0;
    n = 0;
    while (blank_o) begin
      if (tick_i) n++;
      step();
    end
    check(n == BLANK_T, "R5", n, BLANK_T);
    steps(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule